// File: doc/BRIEF.md
# Bus Slave Port with Write Posting

This block lets an external bus master reach a local memory through a slave port. The master raises a strobe together with address, size, direction and write data. It holds those fields steady until the slave answers with a one-cycle acknowledge or a one-cycle bus error, and then it drops the strobe. A single hit input stands in for address decoding. The memory side is a request/ready handshake. A request stays asserted with stable fields until ready is seen high in the same cycle. A read's data is valid in that same cycle.

A three-bit control word sets how the port behaves. Bit 0 opens the port to the bus. Bit 1 restricts it to byte and 16-bit transfers. Bit 2 turns on write posting. With posting on, a write is answered at once and parked in a one-entry buffer, and the block drains that buffer to memory by itself. Any new bus cycle waits until the buffer is empty, so a read that follows a posted write returns the new data.

Top module: `bus_slave_wpost`

## Requirements
- R1: While control bit 0 (port enable) is 0, or while the hit input is low, a strobed cycle gets neither acknowledge nor bus error and causes no memory request.
- R2: Byte lanes follow the size code and the two low address bits (off). Size 0 (byte) uses lane off. Size 1 (half) uses lanes off and off+1. Size 2 (word) uses all four lanes. Lane k is data bits 8k+7..8k. The memory word address is the bus address with its two low bits dropped. Only enabled lanes are written.
- R3: With control bit 1 (narrow mode) set to 1, a word transfer and a half transfer at offset 1 get a bus error. A byte transfer at any offset and a half transfer at offset 0 or 2 are accepted.
- R4: With control bit 1 at 0, an aligned word transfer and a half transfer at offset 1 (lanes 1 and 2) are also accepted.
- R5: A half transfer at offset 3, a word transfer at a nonzero offset, and size code 3 always get a bus error. No memory access follows any bus error.
- R6: With control bit 2 (posting) at 1, a write is acknowledged on the first clock edge after its strobe is sampled, before memory is written. The buffered address, data and lanes are later written to memory unchanged.
- R7: With posting at 0, a write is acknowledged on the clock edge after the memory handshake completes. With W wait cycles, that is 2+W cycles after the strobe is first sampled.
- R8: A read returns the memory word on the read data output in the cycle its acknowledge is high, 2+W cycles after the strobe is first sampled.
- R9: A cycle that arrives while a posted write is still in the buffer gets no response until the buffer has drained. A read of the same word then returns the posted data.
- R10: Acknowledge and bus error are never high together. Each lasts one cycle, and a strobe held high after its response gets no second response.
- R11: Reset clears all three control bits and leaves acknowledge, bus error and memory request low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Load the control word |
| cfg_wdata | input | 3 | Control word: bit 0 enable, bit 1 narrow mode, bit 2 posting |
| bus_strb | input | 1 | Master cycle strobe, held until a response |
| bus_hit | input | 1 | Address decode hit for this slave |
| bus_we | input | 1 | 1 write, 0 read |
| bus_size | input | 2 | 0 byte, 1 half, 2 word, 3 reserved |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Lane-aligned write data |
| bus_ack | output | 1 | One-cycle acknowledge |
| bus_berr | output | 1 | One-cycle bus error |
| bus_rdata | output | 32 | Read word, valid with acknowledge |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW-2 | Memory word address |
| mem_be | output | 4 | Memory byte lane enables |
| mem_wdata | output | 32 | Memory write data |
| mem_rdy | input | 1 | Memory ready, completes the request |
| mem_rdata | input | 32 | Memory read word, valid with ready |

## Verification
The bench goes after the point where a posted acknowledge is checked against a memory that must still hold the old word. A design that waited for memory would show a latency above one cycle there. A design that never drained the buffer would leave the word stale later. Back-to-back posted writes and a read right after a posted write under long memory waits catch a buffer that is overwritten or bypassed, which shows up as a lost first write or a stale read. Off-lane data and width cases at every offset in both modes catch wrong lane masks and wrong error decisions. A strobe held past its acknowledge catches a slave that answers the same cycle twice.

// File: rtl/bs_pkg.sv
// Package: shared constants and types for the bus slave port.
// Assumes a 32-bit data path split into four byte lanes.
package bs_pkg;
    localparam int LANES = 4;
    localparam int DW    = 8 * LANES;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } xfer_size_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WR   = 2'd1,
        ST_RD   = 2'd2,
        ST_REL  = 2'd3
    } slv_state_t;

    typedef struct packed {
        logic post;
        logic narrow;
        logic en;
    } ctl_t;
endpackage

// File: rtl/bs_cfg_reg.sv
// Module: control word register (enable, narrow mode, posting).
// Assumes software writes the whole word at once; reset clears every bit.
module bs_cfg_reg
    import bs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [2:0] wdata,
    output ctl_t       ctl
);
    // Hold the control word; load on write, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl <= '0;
        else if (wr) ctl <= ctl_t'(wdata);
    end

    a_r11_cfg_reset : assert property (@(posedge clk)
        !rst_n |=> (ctl == '0));
endmodule

// File: rtl/bs_width_chk.sv
// Module: decides whether a transfer is legal in the current mode and
// which byte lanes it uses. Purely combinational.
// Assumes the four-lane data path of bs_pkg.
module bs_width_chk
    import bs_pkg::*;
(
    input  logic [1:0]       size,
    input  logic [1:0]       off,
    input  logic             narrow,
    output logic             legal,
    output logic [LANES-1:0] be
);
    xfer_size_t sz;
    assign sz = xfer_size_t'(size);

    // Lane mask and legality from size, offset and mode.
    always_comb begin
        legal = 1'b0;
        be    = '0;
        case (sz)
            SZ_BYTE: begin
                be    = LANES'(1) << off;
                legal = 1'b1;
            end
            SZ_HALF: begin
                be    = LANES'(3) << off;
                legal = (off != 2'd3) && !(narrow && off == 2'd1);
            end
            SZ_WORD: begin
                be    = '1;
                legal = (off == 2'd0) && !narrow;
            end
            default: begin
                be    = '0;
                legal = 1'b0;
            end
        endcase
    end

    // R2: an accepted transfer always enables at least one lane.
    always_comb begin
        if (legal) a_r2_lanes_nonzero : assert (be != '0);
    end
endmodule

// File: rtl/bs_post_buf.sv
// Module: one-entry posted-write buffer (word address, lanes, data).
// Assumes the owner never loads while it holds an entry; the entry
// stays unchanged until the memory handshake for it completes.
module bs_post_buf #(
    parameter int AWW = 8,
    parameter int DW  = 32,
    parameter int NB  = DW / 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [AWW-1:0] ld_addr,
    input  logic [NB-1:0]  ld_be,
    input  logic [DW-1:0]  ld_data,
    input  logic           drain_done,
    output logic           valid,
    output logic [AWW-1:0] addr,
    output logic [NB-1:0]  be,
    output logic [DW-1:0]  data
);
    // Occupancy flag: set on load, cleared when memory takes the write.
    always_ff @(posedge clk) begin
        if (!rst_n) valid <= 1'b0;
        else if (load) valid <= 1'b1;
        else if (drain_done) valid <= 1'b0;
    end

    // Entry payload: captured on load only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
            be   <= '0;
            data <= '0;
        end else if (load) begin
            addr <= ld_addr;
            be   <= ld_be;
            data <= ld_data;
        end
    end

    a_r9_no_overwrite : assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !valid);
    a_r6_entry_held : assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !drain_done) |=> (valid && $stable(addr) && $stable(data) && $stable(be)));
endmodule

// File: rtl/bus_slave_wpost.sv
// Module: bus slave port to local memory with optional write posting.
// Assumes the master holds strobe and fields steady until it sees a
// response, then drops the strobe; the memory holds ready low until done.
module bus_slave_wpost
    import bs_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [2:0]    cfg_wdata,
    input  logic          bus_strb,
    input  logic          bus_hit,
    input  logic          bus_we,
    input  logic [1:0]    bus_size,
    input  logic [AW-1:0] bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic          bus_ack,
    output logic          bus_berr,
    output logic [31:0]   bus_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-3:0] mem_addr,
    output logic [3:0]    mem_be,
    output logic [31:0]   mem_wdata,
    input  logic          mem_rdy,
    input  logic [31:0]   mem_rdata
);
    localparam int AWW = AW - 2;

    ctl_t             ctl;
    slv_state_t       state;
    logic             legal;
    logic [LANES-1:0] xfer_be;
    logic             pb_valid, pb_load, drain_done, start;
    logic [AWW-1:0]   pb_addr;
    logic [LANES-1:0] pb_be;
    logic [DW-1:0]    pb_data;

    bs_cfg_reg u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_wdata), .ctl(ctl)
    );

    bs_width_chk u_wchk (
        .size(bus_size), .off(bus_addr[1:0]), .narrow(ctl.narrow),
        .legal(legal), .be(xfer_be)
    );

    bs_post_buf #(.AWW(AWW), .DW(DW), .NB(LANES)) u_pbuf (
        .clk(clk), .rst_n(rst_n), .load(pb_load),
        .ld_addr(bus_addr[AW-1:2]), .ld_be(xfer_be), .ld_data(bus_wdata),
        .drain_done(drain_done), .valid(pb_valid),
        .addr(pb_addr), .be(pb_be), .data(pb_data)
    );

    // A cycle is taken only when idle, enabled, hit and the buffer is empty.
    assign start      = (state == ST_IDLE) && bus_strb && bus_hit && ctl.en && !pb_valid;
    assign pb_load    = start && legal && bus_we && ctl.post;
    assign drain_done = pb_valid && mem_rdy;

    // Memory port mux: draining buffer first, else the live bus cycle.
    always_comb begin
        if (pb_valid) begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = pb_addr;
            mem_be    = pb_be;
            mem_wdata = pb_data;
        end else begin
            mem_req   = (state == ST_WR) || (state == ST_RD);
            mem_we    = (state == ST_WR);
            mem_addr  = bus_addr[AW-1:2];
            mem_be    = xfer_be;
            mem_wdata = bus_wdata;
        end
    end

    // Cycle sequencer: decide response, run memory access, await release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bus_ack   <= 1'b0;
            bus_berr  <= 1'b0;
            bus_rdata <= '0;
        end else begin
            bus_ack  <= 1'b0;
            bus_berr <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    if (!legal) begin
                        bus_berr <= 1'b1;
                        state    <= ST_REL;
                    end else if (bus_we && ctl.post) begin
                        bus_ack <= 1'b1;
                        state   <= ST_REL;
                    end else if (bus_we) begin
                        state <= ST_WR;
                    end else begin
                        state <= ST_RD;
                    end
                end
                ST_WR, ST_RD: if (mem_rdy) begin
                    bus_ack <= 1'b1;
                    if (state == ST_RD) bus_rdata <= mem_rdata;
                    state <= ST_REL;
                end
                default: if (!bus_strb) state <= ST_IDLE;
            endcase
        end
    end

    a_r10_excl : assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_ack && bus_berr));
    a_r10_ack_pulse : assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);
    a_r1_gate : assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !ctl.en) |=> (!bus_ack && !bus_berr));
    a_r9_stall : assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && pb_valid) |=> (!bus_ack && !bus_berr));
    a_r6_post_ack : assert property (@(posedge clk) disable iff (!rst_n)
        pb_load |=> (bus_ack && pb_valid));
    a_r7_ack_after_mem : assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WR && mem_rdy) |=> bus_ack);
    a_r5_berr_no_mem : assert property (@(posedge clk) disable iff (!rst_n)
        bus_berr |-> (state == ST_REL && !pb_valid));
endmodule

// File: tb/sim_bus_slave_wpost.sv
module sim_bus_slave_wpost;
    localparam int CLK_P = 10;
    localparam int AW    = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_wr = 1'b0;
    logic [2:0] cfg_wdata = '0;
    logic bus_strb = 1'b0, bus_hit = 1'b0, bus_we = 1'b0;
    logic [1:0] bus_size = '0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic bus_ack, bus_berr, mem_req, mem_we, mem_rdy;
    logic [31:0] bus_rdata, mem_wdata, mem_rdata;
    logic [AW-3:0] mem_addr;
    logic [3:0] mem_be;

    int checks = 0, errors = 0, mem_wait = 0, wcnt = 0, req_cycles = 0;
    bit done = 0;
    logic [31:0] mem_q [0:255];

    always #(CLK_P/2) clk = ~clk;

    bus_slave_wpost #(.AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .bus_strb(bus_strb), .bus_hit(bus_hit), .bus_we(bus_we),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_berr(bus_berr), .bus_rdata(bus_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdy(mem_rdy),
        .mem_rdata(mem_rdata)
    );

    // Memory model with a programmable number of wait cycles.
    assign mem_rdy   = mem_req && (wcnt == mem_wait);
    assign mem_rdata = mem_q[mem_addr];
    always @(posedge clk) begin
        if (mem_req) req_cycles++;
        if (mem_req && mem_rdy && mem_we)
            for (int k = 0; k < 4; k++)
                if (mem_be[k]) mem_q[mem_addr][8*k +: 8] <= mem_wdata[8*k +: 8];
        if (!rst_n || !mem_req || mem_rdy) wcnt <= 0;
        else wcnt <= wcnt + 1;
    end

    // Lane merge computed from the lane rule of R2.
    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                          input logic [3:0] m);
        logic [31:0] r = old;
        for (int k = 0; k < 4; k++) if (m[k]) r[8*k +: 8] = d[8*k +: 8];
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic en, input logic narrow, input logic post);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = {post, narrow, en};
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // One bus cycle; returns cycles to response (60 = none).
    task automatic xfer(input logic hit, input logic we, input logic [1:0] sz,
                        input logic [AW-1:0] a, input logic [31:0] d,
                        output int lat, output logic ak, output logic be_,
                        output logic [31:0] rd);
        @(negedge clk);
        bus_strb = 1'b1; bus_hit = hit; bus_we = we; bus_size = sz;
        bus_addr = a; bus_wdata = d;
        lat = 0; ak = 1'b0; be_ = 1'b0;
        while (!ak && !be_ && lat < 60) begin
            @(negedge clk);
            lat++; ak = bus_ack; be_ = bus_berr;
        end
        rd = bus_rdata;
        bus_strb = 1'b0; bus_hit = 1'b0;
    endtask

    task automatic t_reset();
        int lat; logic ak, be_; logic [31:0] rd; int rq;
        chk(!bus_ack && !bus_berr && !mem_req, "R11 outputs idle after reset",
            {bus_ack, bus_berr, mem_req}, 0);
        rq = req_cycles;
        xfer(1, 1, 2, 10'h040, 32'hDEAD0001, lat, ak, be_, rd);
        chk(!ak && !be_ && req_cycles == rq, "R11 enable cleared by reset",
            {ak, be_}, 0);
    endtask

    task automatic t_gate();
        int lat; logic ak, be_; logic [31:0] rd; int rq;
        logic [31:0] old = mem_q[16];
        set_cfg(0, 0, 1);
        rq = req_cycles;
        xfer(1, 1, 2, 10'h040, 32'h11112222, lat, ak, be_, rd);
        chk(!ak && !be_ && req_cycles == rq, "R1 disabled port ignores cycle", {ak, be_}, 0);
        set_cfg(1, 0, 1);
        xfer(0, 1, 2, 10'h040, 32'h11112222, lat, ak, be_, rd);
        repeat (10) @(negedge clk);
        chk(!ak && !be_ && req_cycles == rq, "R1 no hit ignores cycle", {ak, be_}, 0);
        chk(mem_q[16] == old, "R1 memory untouched", mem_q[16], old);
    endtask

    task automatic t_direct();
        int lat; logic ak, be_; logic [31:0] rd, exp;
        set_cfg(1, 0, 0);
        mem_wait = 3;
        xfer(1, 1, 2, 10'h010, 32'hCAFEF00D, lat, ak, be_, rd);
        chk(ak && lat == 5, "R7 write ack after memory, W=3", lat, 5);
        chk(mem_q[4] == 32'hCAFEF00D, "R7 word written", mem_q[4], 32'hCAFEF00D);
        mem_wait = 0;
        exp = merge(mem_q[8], 32'h00AB0000, 4'b0100);
        xfer(1, 1, 0, 10'h022, 32'h00AB0000, lat, ak, be_, rd);
        chk(ak && lat == 2, "R7 write ack, W=0", lat, 2);
        chk(mem_q[8] == exp, "R2 byte lane 2 only", mem_q[8], exp);
        mem_wait = 2;
        xfer(1, 0, 2, 10'h020, 32'h0, lat, ak, be_, rd);
        chk(ak && lat == 4, "R8 read latency W=2", lat, 4);
        chk(rd == exp, "R8 read data", rd, exp);
    endtask

    task automatic t_posted();
        int lat; logic ak, be_; logic [31:0] rd; logic [31:0] old = mem_q[12];
        set_cfg(1, 0, 1);
        mem_wait = 5;
        xfer(1, 1, 2, 10'h030, 32'h5A5A1234, lat, ak, be_, rd);
        chk(ak && lat == 1, "R6 posted ack latency", lat, 1);
        chk(mem_q[12] == old, "R6 ack precedes memory write", mem_q[12], old);
        repeat (10) @(negedge clk);
        chk(mem_q[12] == 32'h5A5A1234, "R6 buffer drained to memory", mem_q[12], 32'h5A5A1234);
    endtask

    task automatic t_stall();
        int lat; logic ak, be_; logic [31:0] rd;
        mem_wait = 6;
        xfer(1, 1, 2, 10'h050, 32'hA0A0A0A0, lat, ak, be_, rd);
        xfer(1, 1, 2, 10'h054, 32'hB1B1B1B1, lat, ak, be_, rd);
        chk(ak && lat > 1, "R9 second write stalled", lat, 2);
        chk(mem_q[20] == 32'hA0A0A0A0, "R9 first write kept", mem_q[20], 32'hA0A0A0A0);
        xfer(1, 1, 1, 10'h05A, 32'hC3C30000, lat, ak, be_, rd);
        xfer(1, 0, 2, 10'h058, 32'h0, lat, ak, be_, rd);
        chk(ak && rd == merge(mem_q[22], 32'hC3C30000, 4'b1100),
            "R9 read after posted write sees new data", rd,
            merge(mem_q[22], 32'hC3C30000, 4'b1100));
        repeat (10) @(negedge clk);
        chk(mem_q[21] == 32'hB1B1B1B1, "R9 second write landed", mem_q[21], 32'hB1B1B1B1);
    endtask

    task automatic t_narrow();
        int lat; logic ak, be_; logic [31:0] rd; int rq;
        set_cfg(1, 1, 0);
        mem_wait = 1;
        rq = req_cycles;
        xfer(1, 1, 2, 10'h060, 32'h12345678, lat, ak, be_, rd);
        chk(be_ && !ak, "R3 word rejected in narrow mode", {ak, be_}, 1);
        xfer(1, 0, 1, 10'h061, 32'h0, lat, ak, be_, rd);
        chk(be_ && !ak, "R3 half offset 1 rejected in narrow mode", {ak, be_}, 1);
        chk(req_cycles == rq, "R5 no memory access on bus error", req_cycles, rq);
        xfer(1, 1, 0, 10'h063, 32'h77000000, lat, ak, be_, rd);
        chk(ak && !be_, "R3 byte accepted in narrow mode", {ak, be_}, 2);
        xfer(1, 1, 1, 10'h062, 32'h99880000, lat, ak, be_, rd);
        chk(ak && mem_q[24][31:16] == 16'h9988, "R3 half offset 2 accepted",
            mem_q[24], 32'h99880000);
    endtask

    task automatic t_wide();
        int lat; logic ak, be_; logic [31:0] rd, exp;
        set_cfg(1, 0, 0);
        exp = merge(mem_q[30], 32'h00CDEF00, 4'b0110);
        xfer(1, 1, 1, 10'h079, 32'h00CDEF00, lat, ak, be_, rd);
        chk(ak && mem_q[30] == exp, "R4 half offset 1 uses lanes 1 and 2", mem_q[30], exp);
        xfer(1, 1, 1, 10'h07B, 32'h0, lat, ak, be_, rd);
        chk(be_ && !ak, "R5 half offset 3 rejected", {ak, be_}, 1);
        xfer(1, 1, 2, 10'h07A, 32'h0, lat, ak, be_, rd);
        chk(be_ && !ak, "R5 word offset 2 rejected", {ak, be_}, 1);
        xfer(1, 0, 3, 10'h078, 32'h0, lat, ak, be_, rd);
        chk(be_ && !ak, "R5 size code 3 rejected", {ak, be_}, 1);
        chk(mem_q[30] == exp, "R5 rejected writes leave memory", mem_q[30], exp);
    endtask

    task automatic t_once();
        int acks = 0, both = 0;
        set_cfg(1, 0, 1);
        mem_wait = 0;
        @(negedge clk);
        bus_strb = 1'b1; bus_hit = 1'b1; bus_we = 1'b1; bus_size = 2;
        bus_addr = 10'h0A0; bus_wdata = 32'h0F0F0F0F;
        repeat (12) begin
            @(negedge clk);
            if (bus_ack) acks++;
            if (bus_ack && bus_berr) both++;
        end
        bus_strb = 1'b0; bus_hit = 1'b0;
        chk(acks == 1 && both == 0, "R10 one response per held strobe", acks, 1);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem_q[i] = 32'h3C000000 + i * 32'h00010101;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_gate();
        t_direct();
        t_posted();
        t_stall();
        t_narrow();
        t_wide();
        t_once();
        repeat (5) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog all-requirements actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule